// File: doc/BRIEF.md
# Host Memory Access Port

This block lets an external host processor read and write the on-chip program and data RAM without stopping the core. The host drives a 16-bit bus that carries both addresses and data. It has four strobes: select, address latch, read and write. It also has one acknowledge line. The host places a start address on the bus and drops the latch strobe. After that it issues plain read or write strobes, and the port steps its own pointer after every completed word. A block transfer therefore needs only one address cycle.

The host strobes are not tied to the core clock. The port passes them through flop synchronisers and acts on edges of the synchronised levels. For each word it takes at most one memory cycle from the core-side RAM port. Program memory is 24 bits wide, so each program word travels as two bus transfers. The data-memory words at the top of the address space hold control registers, and host writes there are dropped. The core can also load the pointer directly.

Top module: `host_mem_port`

## Requirements
- R1: While reset is active and right after it, `hostAck` is 1, `memReq` is 0 and `hostAdOe` is 0.
- R2: Address cycle. The port captures the pointer on a falling edge of `hostAle` while `hostSel` is held. Bus bits [13:0] give the word address. Bit 14 picks the space (1 = program, 0 = data). If bit 15 is 1, the address cycle is ignored and the pointer is left unchanged.
- R3: The host asserts `hostSel` together with `hostRd` or `hostWr` before clock edge 1. `hostAck` stays 1 after edges 1 and 2 and goes 0 after edge 3. It returns to 1 after edge 4, except for a transfer that reads memory, which returns after edge 5. A memory request lasts exactly one cycle.
- R4: A data-memory write stores the bus value in `memWdata[15:0]` with bits [23:16] zero. The pointer then advances by one.
- R5: On a data-memory read, `hostAdOut` carries `memRdata[15:0]` once `hostAck` has returned. `hostAdOe` is 1 while `hostSel` and `hostRd` are both high.
- R6: A program-memory write uses two transfers. The first carries word bits [23:8]. The second carries bits [7:0] in bus bits [7:0]. The port issues one memory write of the whole word, and the pointer advances only after the second transfer.
- R7: A program-memory read issues one memory read on the first transfer and returns bits [23:8]. The second transfer returns {8'h00, bits [7:0]} without touching memory. The pointer advances after the second transfer.
- R8: A data-memory write to an address at or above 0x3FE0 issues no memory request, and the pointer still advances. Reads of that range behave normally.
- R9: A one-cycle pulse on `corePtrLd` loads the pointer from `corePtrVal` (bit 14 picks the space, bits [13:0] the address). It also restarts the program-word half sequence.
- R10: The pointer wraps from 0x3FFF to 0x0000.
- R11: An accepted host address cycle restarts the program-word half sequence, so the next transfer is a first half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostSel | input | 1 | Host select, active high, asynchronous |
| hostAle | input | 1 | Address latch strobe, falling edge captures |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostAdIn | input | 16 | Address/data bus driven by host |
| hostAdOut | output | 16 | Read data toward host |
| hostAdOe | output | 1 | Enable for driving the bus back to the host |
| hostAck | output | 1 | 1 = idle/previous transfer finished, 0 = busy |
| corePtrLd | input | 1 | Core load of the pointer |
| corePtrVal | input | 15 | Space bit and address for the core load |
| memReq | output | 1 | One-cycle RAM access request |
| memWe | output | 1 | Request is a write |
| memIsPm | output | 1 | 1 = program RAM, 0 = data RAM |
| memAddr | output | 14 | RAM word address |
| memWdata | output | 24 | RAM write data |
| memRdata | input | 24 | RAM read data, valid the cycle after a read request |

## Verification
The assertions rely on two assumptions about the host. First, it holds each strobe and the bus value steady for several core cycles, and waits for acknowledge before dropping a strobe. Second, it never pulses `corePtrLd` during a transfer. The bench stimulus keeps to both rules. Every strobe is held until acknowledge returns, the bus stays stable for four cycles after a strobe falls, and pointer loads happen only between transfers. Under those conditions the assertions check three things: a request never coincides with acknowledge high, a request lasts one cycle, and the protected range is never written.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_RDWAIT = 2'd2
  } hmpState_t;

  typedef struct packed {
    logic latchAddr;
    logic loadCore;
    logic capWr;
    logic opWrite;
    logic memReq;
    logic memWe;
    logic takeMem;
    logic takeHold;
    logic stepPtr;
  } hmpStrobe_t;
endpackage

// File: rtl/hmp_sync.sv
module hmp_sync #(
  parameter int STAGES = 2,
  parameter int BUS_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             ale,
  input  logic             rd,
  input  logic             wr,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busS,
  output logic             aleFall,
  output logic             rdRise,
  output logic             wrRise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][3:0]      lvlPipe;
  logic [STAGES-1:0][BUS_W-1:0] busPipe;
  logic [3:0] lvlNow, lvlPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlPipe <= '0;
      busPipe <= '0;
      lvlPrev <= '0;
    end else begin
      lvlPipe[0] <= {sel, ale, rd, wr};
      busPipe[0] <= busIn;
      for (int i = 1; i < STAGES; i++) begin
        lvlPipe[i] <= lvlPipe[i-1];
        busPipe[i] <= busPipe[i-1];
      end
      lvlPrev <= lvlPipe[LAST];
    end
  end

  assign lvlNow = lvlPipe[LAST];
  assign busS   = busPipe[LAST];

  // bit 3 sel, bit 2 ale, bit 1 rd, bit 0 wr
  assign aleFall = lvlNow[3] & lvlPrev[2] & ~lvlNow[2];
  assign rdRise  = (lvlNow[3] & lvlNow[1]) & ~(lvlPrev[3] & lvlPrev[1]);
  assign wrRise  = (lvlNow[3] & lvlNow[0]) & ~(lvlPrev[3] & lvlPrev[0]);
endmodule

// File: rtl/hmp_ctrl.sv
module hmp_ctrl (
  input  logic               clk,
  input  logic               rstN,
  input  logic               aleFall,
  input  logic               rdRise,
  input  logic               wrRise,
  input  logic               busTopBit,
  input  logic               corePtrLd,
  input  logic               isPm,
  input  logic               phase,
  input  logic               protHit,
  output hmp_pkg::hmpStrobe_t st,
  output logic               busy
);
  import hmp_pkg::*;

  hmpState_t state;
  logic opWrite;
  logic needMem;

  always_comb begin
    if (opWrite) needMem = isPm ? phase : ~protHit;
    else         needMem = ~isPm | ~phase;
  end

  always_comb begin
    st = '0;
    st.opWrite   = opWrite;
    st.loadCore  = corePtrLd;
    st.latchAddr = aleFall & ~busTopBit & ~corePtrLd;
    st.capWr     = (state == ST_IDLE) & wrRise;
    case (state)
      ST_ACCESS: begin
        st.memReq = needMem;
        st.memWe  = opWrite & needMem;
        if (opWrite) begin
          st.stepPtr = 1'b1;
        end else if (!needMem) begin
          st.takeHold = 1'b1;
          st.stepPtr  = 1'b1;
        end
      end
      ST_RDWAIT: begin
        st.takeMem = 1'b1;
        st.stepPtr = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opWrite <= 1'b0;
      busy    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (rdRise || wrRise) begin
          state   <= ST_ACCESS;
          opWrite <= wrRise;
          busy    <= 1'b1;
        end
        ST_ACCESS: begin
          if (opWrite || !needMem) begin
            state <= ST_IDLE;
            busy  <= 1'b0;
          end else begin
            state <= ST_RDWAIT;
          end
        end
        ST_RDWAIT: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hmp_datapath.sv
module hmp_datapath #(
  parameter int          ADDR_W    = 14,
  parameter int          BUS_W     = 16,
  parameter int          WORD_W    = 24,
  parameter logic [13:0] PROT_BASE = 14'h3FE0
) (
  input  logic                clk,
  input  logic                rstN,
  input  hmp_pkg::hmpStrobe_t st,
  input  logic [BUS_W-1:0]    busS,
  input  logic [ADDR_W:0]     corePtrVal,
  input  logic [WORD_W-1:0]   memRdata,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                memIsPm,
  output logic [WORD_W-1:0]   memWdata,
  output logic [BUS_W-1:0]    rdData,
  output logic                phase,
  output logic                protHit
);
  localparam int LOW_W = WORD_W - BUS_W;

  logic [ADDR_W-1:0] ptr;
  logic              ptrPm;
  logic [BUS_W-1:0]  hold;
  logic [BUS_W-1:0]  wrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr    <= '0;
      ptrPm  <= 1'b0;
      phase  <= 1'b0;
      hold   <= '0;
      wrReg  <= '0;
      rdData <= '0;
    end else begin
      if (st.loadCore) begin
        ptr   <= corePtrVal[ADDR_W-1:0];
        ptrPm <= corePtrVal[ADDR_W];
        phase <= 1'b0;
      end else if (st.latchAddr) begin
        ptr   <= busS[ADDR_W-1:0];
        ptrPm <= busS[ADDR_W];
        phase <= 1'b0;
      end else if (st.stepPtr) begin
        if (ptrPm) phase <= ~phase;
        if (!ptrPm || phase) ptr <= ptr + 1'b1;
      end

      if (st.capWr) wrReg <= busS;

      if (st.stepPtr && st.opWrite && ptrPm && !phase) hold <= wrReg;
      if (st.takeMem && ptrPm) hold <= {{(BUS_W-LOW_W){1'b0}}, memRdata[LOW_W-1:0]};

      if (st.takeMem)
        rdData <= ptrPm ? memRdata[WORD_W-1:LOW_W] : memRdata[BUS_W-1:0];
      else if (st.takeHold)
        rdData <= {{(BUS_W-LOW_W){1'b0}}, hold[LOW_W-1:0]};
    end
  end

  assign memAddr  = ptr;
  assign memIsPm  = ptrPm;
  assign memWdata = ptrPm ? {hold, wrReg[LOW_W-1:0]} : {{LOW_W{1'b0}}, wrReg};
  assign protHit  = ~ptrPm & (ptr >= PROT_BASE);
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port #(
  parameter int          ADDR_W      = 14,
  parameter int          BUS_W       = 16,
  parameter int          WORD_W      = 24,
  parameter int          SYNC_STAGES = 2,
  parameter logic [13:0] PROT_BASE   = 14'h3FE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostAle,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [BUS_W-1:0]  hostAdIn,
  output logic [BUS_W-1:0]  hostAdOut,
  output logic              hostAdOe,
  output logic              hostAck,
  input  logic              corePtrLd,
  input  logic [ADDR_W:0]   corePtrVal,
  output logic              memReq,
  output logic              memWe,
  output logic              memIsPm,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata
);
  import hmp_pkg::*;

  logic [BUS_W-1:0] busS;
  logic aleFall, rdRise, wrRise;
  logic phase, protHit, busy;
  hmpStrobe_t st;

  hmp_sync #(.STAGES(SYNC_STAGES), .BUS_W(BUS_W)) sync_i (
    .clk(clk), .rstN(rstN), .sel(hostSel), .ale(hostAle), .rd(hostRd), .wr(hostWr),
    .busIn(hostAdIn), .busS(busS), .aleFall(aleFall), .rdRise(rdRise), .wrRise(wrRise)
  );

  hmp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .aleFall(aleFall), .rdRise(rdRise), .wrRise(wrRise),
    .busTopBit(busS[BUS_W-1]), .corePtrLd(corePtrLd), .isPm(memIsPm), .phase(phase),
    .protHit(protHit), .st(st), .busy(busy)
  );

  hmp_datapath #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .WORD_W(WORD_W), .PROT_BASE(PROT_BASE)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .busS(busS), .corePtrVal(corePtrVal),
    .memRdata(memRdata), .memAddr(memAddr), .memIsPm(memIsPm), .memWdata(memWdata),
    .rdData(hostAdOut), .phase(phase), .protHit(protHit)
  );

  assign memReq   = st.memReq;
  assign memWe    = st.memWe;
  assign hostAck  = ~busy;
  assign hostAdOe = hostSel & hostRd;
endmodule

// File: rtl/hmp_checker.sv
module hmp_checker #(
  parameter int          ADDR_W    = 14,
  parameter logic [13:0] PROT_BASE = 14'h3FE0
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostAck,
  input logic              memReq,
  input logic              memWe,
  input logic              memIsPm,
  input logic [ADDR_W-1:0] memAddr
);
  a_r3_req_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !hostAck);

  a_r3_single_req: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  a_r3_ack_after_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostAck) |-> !memReq);

  a_r8_no_prot_write: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && !memIsPm) |-> (memAddr < PROT_BASE));
endmodule

bind host_mem_port hmp_checker #(.ADDR_W(ADDR_W), .PROT_BASE(PROT_BASE)) chk_i (
  .clk(clk), .rstN(rstN), .hostAck(hostAck), .memReq(memReq), .memWe(memWe),
  .memIsPm(memIsPm), .memAddr(memAddr)
);

// File: tb/host_mem_port_tb_top.sv
module host_mem_port_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostSel = 0, hostAle = 0, hostRd = 0, hostWr = 0;
  logic [15:0] hostAdIn = '0;
  logic [15:0] hostAdOut;
  logic hostAdOe, hostAck;
  logic corePtrLd = 0;
  logic [14:0] corePtrVal = '0;
  logic memReq, memWe, memIsPm;
  logic [13:0] memAddr;
  logic [23:0] memWdata;
  logic [23:0] memRdata = '0;

  int nChk = 0, nFail = 0, cycles = 0;
  logic [23:0] pmMem [int];
  logic [23:0] dmMem [int];
  int mAddr = 0;
  bit mPm = 0, mPhase = 0;

  always #4 clk = ~clk;

  host_mem_port dut_i (.*);

  // behavioural RAM
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) begin
        if (memIsPm) pmMem[int'(memAddr)] = memWdata;
        else         dmMem[int'(memAddr)] = memWdata;
      end else begin
        if (memIsPm) memRdata <= pmMem.exists(int'(memAddr)) ? pmMem[int'(memAddr)] : 24'h0;
        else         memRdata <= dmMem.exists(int'(memAddr)) ? dmMem[int'(memAddr)] : 24'h0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison of memory traffic against model pointer
  always @(negedge clk) begin
    if (rstN && memReq) begin
      check(memAddr == mAddr[13:0] && memIsPm == mPm, "R2 pointer",
            {17'h0, memIsPm, memAddr}, {17'h0, mPm, mAddr[13:0]});
      if (memWe && !memIsPm) check(memAddr < 14'h3FE0, "R8 protect", {18'h0, memAddr}, 32'h3FE0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      check(1'b0, "watchdog", cycles, 100000);
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  task automatic modelStep();
    if (mPm) begin
      if (mPhase) mAddr = (mAddr + 1) & 32'h3FFF;
      mPhase = !mPhase;
    end else mAddr = (mAddr + 1) & 32'h3FFF;
  endtask

  task automatic latchAddr(input logic [15:0] a);
    @(negedge clk); hostSel = 1; hostAle = 1; hostAdIn = a;
    repeat (3) @(negedge clk);
    hostAle = 0;
    repeat (4) @(negedge clk);
    hostSel = 0;
    repeat (2) @(negedge clk);
    if (!a[15]) begin mAddr = int'(a[13:0]); mPm = a[14]; mPhase = 0; end
  endtask

  task automatic coreLoad(input logic [14:0] v);
    @(negedge clk); corePtrLd = 1; corePtrVal = v;
    @(negedge clk); corePtrLd = 0;
    mAddr = int'(v[13:0]); mPm = v[14]; mPhase = 0;
  endtask

  task automatic doOp(input bit isWr, input logic [15:0] d, input int lowCyc, output logic [15:0] rd);
    @(negedge clk);
    hostSel = 1; hostAdIn = d;
    if (isWr) hostWr = 1; else hostRd = 1;
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      check(hostAck == !(c >= 3 && c < 3 + lowCyc), "R3 ack timing", {31'h0, hostAck},
            {31'h0, !(c >= 3 && c < 3 + lowCyc)});
    end
    if (!isWr) check(hostAdOe == 1'b1, "R5 oe", {31'h0, hostAdOe}, 1);
    rd = hostAdOut;
    hostSel = 0; hostRd = 0; hostWr = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic dmWrite(input logic [15:0] d);
    logic [15:0] rd;
    int a;
    a = mAddr;
    doOp(1, d, 1, rd);
    if (a < 'h3FE0)
      check(dmMem.exists(a) && dmMem[a] == {8'h0, d}, "R4 dm write", dmMem.exists(a) ? dmMem[a] : 0, {8'h0, d});
    modelStep();
  endtask

  task automatic dmRead(input logic [15:0] exp, input string req);
    logic [15:0] rd;
    doOp(0, 16'h0, 2, rd);
    check(rd == exp, req, rd, exp);
    modelStep();
  endtask

  task automatic pmWrite(input logic [23:0] w);
    logic [15:0] rd;
    int a;
    a = mAddr;
    doOp(1, w[23:8], 1, rd);
    modelStep();
    doOp(1, {8'hC3, w[7:0]}, 1, rd);
    modelStep();
    check(pmMem.exists(a) && pmMem[a] == w, "R6 pm write", pmMem.exists(a) ? pmMem[a] : 0, w);
  endtask

  task automatic pmRead(input logic [23:0] w);
    logic [15:0] rd;
    doOp(0, 16'h0, 2, rd);
    check(rd == w[23:8], "R7 pm upper", rd, w[23:8]);
    modelStep();
    doOp(0, 16'h0, 1, rd);
    check(rd == {8'h0, w[7:0]}, "R7 pm lower", rd, {8'h0, w[7:0]});
    modelStep();
  endtask

  initial begin
    logic [15:0] rd;
    dmMem[32'h3FE0] = 24'h00BEEF;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(hostAck == 1 && memReq == 0 && hostAdOe == 0, "R1 in reset", {hostAck, memReq, hostAdOe}, 3'b100);
    rstN = 1;
    @(negedge clk);
    check(hostAck == 1 && memReq == 0 && hostAdOe == 0, "R1 after reset", {hostAck, memReq, hostAdOe}, 3'b100);

    // R2/R4 data writes with auto-increment
    latchAddr(16'h0100);
    dmWrite(16'h1111); dmWrite(16'h2222); dmWrite(16'h3333);
    latchAddr(16'h0100);
    dmRead(16'h1111, "R5 read0"); dmRead(16'h2222, "R5 read1"); dmRead(16'h3333, "R5 read2");

    // R2 bit 15 set: address cycle ignored
    latchAddr(16'h0100);
    latchAddr(16'h8200);
    dmRead(16'h1111, "R2 bit15 ignored");

    // R6/R7 program words
    latchAddr(16'h4020);
    pmWrite(24'hABCDEF); pmWrite(24'h123456);
    latchAddr(16'h4020);
    pmRead(24'hABCDEF); pmRead(24'h123456);

    // R11 latch restarts half sequence
    latchAddr(16'h4020);
    doOp(0, 16'h0, 2, rd);
    check(rd == 16'hABCD, "R7 half", rd, 16'hABCD);
    modelStep();
    latchAddr(16'h4021);
    pmRead(24'h123456);

    // R9 core load restarts half sequence
    latchAddr(16'h4020);
    doOp(0, 16'h0, 2, rd);
    modelStep();
    coreLoad(15'h4020);
    pmRead(24'hABCDEF);
    coreLoad(15'h0101);
    dmRead(16'h2222, "R9 core load");

    // R8 protected range
    latchAddr(16'h3FDF);
    dmWrite(16'h5555);
    dmWrite(16'h6666);
    dmWrite(16'h7777);
    check(dmMem[32'h3FE0] == 24'h00BEEF, "R8 unchanged", dmMem[32'h3FE0], 24'h00BEEF);
    check(!dmMem.exists(32'h3FE1), "R8 no write", dmMem.exists(32'h3FE1), 0);
    check(mAddr == 32'h3FE2, "R8 pointer advances", mAddr, 32'h3FE2);
    dmRead(16'h0000, "R8 advanced read");
    latchAddr(16'h3FE0);
    dmRead(16'hBEEF, "R8 read allowed");

    // R10 wrap
    latchAddr(16'h7FFF);
    pmWrite(24'h0F0F0F);
    pmWrite(24'h111111);
    check(pmMem.exists(0) && pmMem[0] == 24'h111111, "R10 wrap", pmMem.exists(0) ? pmMem[0] : 0, 24'h111111);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule